// File: doc/BRIEF.md
# Transmit power ramp sequencer

This block runs the transmit side of a radio link from a firmware start request to the end of the frame. Firmware loads every byte of the frame into a small transmit FIFO, including preamble, delimiter and any header. It then raises a start request. The block turns on the transceiver sections one at a time: command enable, then power-amplifier enable, then modulator enable. Two configuration words set the gaps between these steps. After the last gap it drains the FIFO and shifts each byte out serially on a data pin. Each bit lasts a programmed number of clock cycles.

When the FIFO runs dry, the frame either ends normally or is cut short. It ends normally if firmware has flagged end of frame. Otherwise it is an underrun. In both cases the enables turn off in the reverse order and a completion pulse follows. A second mode serves transceivers that sequence their own power. In that mode the block raises only the command enable and waits for a clear-to-send input before it sends data. The FIFO asks for more data whenever it has room, whether or not a frame is running.

Top module: `tx_ramp_sequencer`

## Requirements
- R1: A one-cycle pulse on `start_i` sets `start_pend_o` on that clock edge. On the next edge, with the block idle, `start_pend_o` clears and `tx_cmd_o` rises.
- R2: In internal mode, `tx_pa_o` rises G0+1 cycles after `tx_cmd_o` and `tx_mod_o` rises G1+1 cycles after `tx_pa_o`. `ramp_up_cfg_i` holds G0 in bits [DLY_W-1:0], G1 in bits [2*DLY_W-1:DLY_W] and G2 in bits [3*DLY_W-1:2*DLY_W]. No higher enable is ever on without every lower one.
- R3: `tx_data_o` stays low until the first data bit. The first data bit appears G2+2 cycles after `tx_mod_o` rises, and no data is sent while `tx_cmd_o` is low.
- R4: Each byte goes out least significant bit first. Every bit lasts `baud_div_i`+1 cycles. Bytes already waiting in the FIFO follow each other with no idle cycle.
- R5: Suppose the FIFO is empty when a byte finishes and end of frame has been flagged through `eof_i`. Then `tx_mod_o` falls H0+1 cycles after the last bit ends, `tx_pa_o` falls H1+1 cycles later and `tx_cmd_o` falls H2+1 cycles after that. H0, H1 and H2 sit in `ramp_dn_cfg_i` at the same field positions as G0, G1 and G2 in `ramp_up_cfg_i`.
- R6: On the edge where `tx_cmd_o` falls at the end of a frame, `done_o` goes high and stays high. `irq_o` is high for exactly that one cycle.
- R7: Suppose the FIFO is empty when a byte is needed and end of frame has not been flagged. Then `underrun_o` sets and stays set, and `tx_mod_o` falls on that same edge. `tx_pa_o` and `tx_cmd_o` then follow after H1+1 and H2+1 cycles.
- R8: If `self_seq_i` is high at the start, `tx_pa_o` and `tx_mod_o` stay low for the whole frame. The first data bit appears on the second edge after the edge that samples `cts_i` high. `tx_cmd_o` falls on the edge where the frame ends, together with `irq_o`.
- R9: In the clear-to-send mode, while `cts_i` stays low the block holds `tx_cmd_o` high and keeps `tx_data_o` low.
- R10: The FIFO holds up to FIFO_DEPTH bytes (8 by default). `fifo_cnt_o` reports the count. `drq_o` is high exactly when the count is below FIFO_DEPTH, in any state. A write while the FIFO is full is dropped.
- R11: `done_o` and `underrun_o` clear when the next frame starts. The end-of-frame flag is used up by the frame that ends on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write one byte into the transmit FIFO |
| wr_data_i | input | 8 | Byte to write |
| drq_o | output | 1 | FIFO has room: data request |
| fifo_cnt_o | output | $clog2(FIFO_DEPTH+1) | Bytes held in the FIFO |
| start_i | input | 1 | Start request pulse |
| eof_i | input | 1 | Flag end of frame (held until the frame ends) |
| self_seq_i | input | 1 | 1: wait for clear-to-send instead of running the ramp |
| cts_i | input | 1 | Clear-to-send from a self-sequencing transceiver |
| ramp_up_cfg_i | input | 3*DLY_W | Ramp-up gaps G0, G1, G2 |
| ramp_dn_cfg_i | input | 3*DLY_W | Ramp-down gaps H0, H1, H2 |
| baud_div_i | input | DIV_W | Cycles per bit minus one |
| start_pend_o | output | 1 | Start request waiting to be taken |
| tx_cmd_o | output | 1 | Transceiver command enable |
| tx_pa_o | output | 1 | Power-amplifier enable |
| tx_mod_o | output | 1 | Modulator enable |
| tx_data_o | output | 1 | Serial transmit data |
| done_o | output | 1 | Last frame completed (sticky) |
| irq_o | output | 1 | One-cycle completion pulse |
| underrun_o | output | 1 | Last frame ended by underrun (sticky) |

## Verification
Frames are run over a sweep of bit dividers from 0 to 3, frame lengths of 0, 1, 2, 3, 4, 8 and 9 bytes, and gap settings from all zero to the field maximum. Mismatched gap values make each ramp edge land on a cycle that only the correct field can produce. Frames with and without the end-of-frame flag separate the graceful ramp-down from the underrun path. An empty frame and a nine-byte load cover the two FIFO limits. The clear-to-send runs hold `cts_i` low for several cycles first, so a block that ignores the handshake, or that still drives the internal ramp in that mode, shows up in the enable timing and the bit stream.

// File: rtl/tx_ramp_pkg.sv
package tx_ramp_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CMD_ON,
      ST_PA_ON,
      ST_MOD_ON,
      ST_CTS_WAIT,
      ST_STREAM,
      ST_HOLD_MOD,
      ST_HOLD_PA,
      ST_HOLD_CMD
   } ramp_state_e;

endpackage

// File: rtl/tx_ramp_fifo.sv
module tx_ramp_fifo #(
   parameter int DEPTH = 8,
   parameter int DW    = 8,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] count
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_wr, do_rd;

   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
   assign do_wr = wr_en && !full;
   assign do_rd = rd_en && !empty;

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_wr) wp <= (wp == LAST) ? '0 : wp + AW'(1);
         if (do_rd) rp <= (rp == LAST) ? '0 : rp + AW'(1);
         cnt <= cnt + CW'(do_wr) - CW'(do_rd);
      end
   end

   assign rd_data = mem[rp];
   assign count   = cnt;

endmodule

// File: rtl/tx_ramp_shifter.sv
module tx_ramp_shifter #(
   parameter int DIV_W     = 4,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [DIV_W-1:0] baud_div,
   input  logic             fifo_empty,
   input  logic [7:0]       fifo_data,
   output logic             pop,
   output logic             starved,
   output logic             txd
);
   logic [7:0]       sh, sh_next;
   logic [2:0]       bit_idx;
   logic [DIV_W-1:0] baud;
   logic             loaded, cur_bit, byte_end, need;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign cur_bit = sh[0];
         assign sh_next = {1'b0, sh[7:1]};
      end else begin : g_msb
         assign cur_bit = sh[7];
         assign sh_next = {sh[6:0], 1'b0};
      end
   endgenerate

   assign byte_end = loaded && (baud == '0) && (bit_idx == 3'd7);
   assign need     = active && (!loaded || byte_end);
   assign pop      = need && !fifo_empty;
   assign starved  = need && fifo_empty;
   assign txd      = loaded && cur_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh      <= '0;
         bit_idx <= '0;
         baud    <= '0;
         loaded  <= 1'b0;
      end else if (!active) begin
         loaded <= 1'b0;
      end else if (need) begin
         if (!fifo_empty) begin
            sh      <= fifo_data;
            bit_idx <= '0;
            baud    <= baud_div;
            loaded  <= 1'b1;
         end else begin
            loaded <= 1'b0;
         end
      end else if (baud == '0) begin
         sh      <= sh_next;
         bit_idx <= bit_idx + 3'd1;
         baud    <= baud_div;
      end else begin
         baud <= baud - DIV_W'(1);
      end
   end

endmodule

// File: rtl/tx_ramp_ctrl.sv
module tx_ramp_ctrl
   import tx_ramp_pkg::*;
#(
   parameter int DLY_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               eof_i,
   input  logic               self_seq_i,
   input  logic               cts_i,
   input  logic [3*DLY_W-1:0] up_cfg,
   input  logic [3*DLY_W-1:0] dn_cfg,
   input  logic               starved,
   output logic               stream_on,
   output logic               start_pend,
   output logic               en_cmd,
   output logic               en_pa,
   output logic               en_mod,
   output logic               done,
   output logic               irq,
   output logic               underrun
);
   ramp_state_e      state;
   logic [DLY_W-1:0] cnt;
   logic             mode_q, start_q, eof_q, done_q, irq_q, urun_q;
   logic [DLY_W-1:0] up0, up1, up2, dn0, dn1, dn2;
   logic             gap_done;

   assign up0 = up_cfg[DLY_W-1:0];
   assign up1 = up_cfg[2*DLY_W-1:DLY_W];
   assign up2 = up_cfg[3*DLY_W-1:2*DLY_W];
   assign dn0 = dn_cfg[DLY_W-1:0];
   assign dn1 = dn_cfg[2*DLY_W-1:DLY_W];
   assign dn2 = dn_cfg[3*DLY_W-1:2*DLY_W];
   assign gap_done = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         mode_q  <= 1'b0;
         start_q <= 1'b0;
         eof_q   <= 1'b0;
         done_q  <= 1'b0;
         irq_q   <= 1'b0;
         urun_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (start_i) start_q <= 1'b1;
         if (eof_i)   eof_q   <= 1'b1;
         case (state)
            ST_IDLE: begin
               if (start_q) begin
                  start_q <= start_i;
                  mode_q  <= self_seq_i;
                  done_q  <= 1'b0;
                  urun_q  <= 1'b0;
                  cnt     <= up0;
                  state   <= self_seq_i ? ST_CTS_WAIT : ST_CMD_ON;
               end
            end
            ST_CMD_ON: begin
               if (gap_done) begin
                  cnt   <= up1;
                  state <= ST_PA_ON;
               end else cnt <= cnt - DLY_W'(1);
            end
            ST_PA_ON: begin
               if (gap_done) begin
                  cnt   <= up2;
                  state <= ST_MOD_ON;
               end else cnt <= cnt - DLY_W'(1);
            end
            ST_MOD_ON: begin
               if (gap_done) state <= ST_STREAM;
               else cnt <= cnt - DLY_W'(1);
            end
            ST_CTS_WAIT: begin
               if (cts_i) state <= ST_STREAM;
            end
            ST_STREAM: begin
               if (starved) begin
                  eof_q <= eof_i;
                  if (!eof_q) urun_q <= 1'b1;
                  if (mode_q) begin
                     done_q <= 1'b1;
                     irq_q  <= 1'b1;
                     state  <= ST_IDLE;
                  end else if (eof_q) begin
                     cnt   <= dn0;
                     state <= ST_HOLD_MOD;
                  end else begin
                     cnt   <= dn1;
                     state <= ST_HOLD_PA;
                  end
               end
            end
            ST_HOLD_MOD: begin
               if (gap_done) begin
                  cnt   <= dn1;
                  state <= ST_HOLD_PA;
               end else cnt <= cnt - DLY_W'(1);
            end
            ST_HOLD_PA: begin
               if (gap_done) begin
                  cnt   <= dn2;
                  state <= ST_HOLD_CMD;
               end else cnt <= cnt - DLY_W'(1);
            end
            ST_HOLD_CMD: begin
               if (gap_done) begin
                  done_q <= 1'b1;
                  irq_q  <= 1'b1;
                  state  <= ST_IDLE;
               end else cnt <= cnt - DLY_W'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      en_pa  = 1'b0;
      en_mod = 1'b0;
      case (state)
         ST_PA_ON, ST_HOLD_PA: en_pa = 1'b1;
         ST_MOD_ON, ST_HOLD_MOD: begin
            en_pa  = 1'b1;
            en_mod = 1'b1;
         end
         ST_STREAM: begin
            en_pa  = !mode_q;
            en_mod = !mode_q;
         end
         default: ;
      endcase
   end

   assign en_cmd     = (state != ST_IDLE);
   assign stream_on  = (state == ST_STREAM);
   assign start_pend = start_q;
   assign done       = done_q;
   assign irq        = irq_q;
   assign underrun   = urun_q;

endmodule

// File: rtl/tx_ramp_sequencer.sv
module tx_ramp_sequencer #(
   parameter int FIFO_DEPTH = 8,
   parameter int DLY_W      = 4,
   parameter int DIV_W      = 4,
   parameter bit LSB_FIRST  = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en_i,
   input  logic [7:0]                        wr_data_i,
   output logic                              drq_o,
   output logic [$clog2(FIFO_DEPTH+1)-1:0]   fifo_cnt_o,
   input  logic                              start_i,
   input  logic                              eof_i,
   input  logic                              self_seq_i,
   input  logic                              cts_i,
   input  logic [3*DLY_W-1:0]                ramp_up_cfg_i,
   input  logic [3*DLY_W-1:0]                ramp_dn_cfg_i,
   input  logic [DIV_W-1:0]                  baud_div_i,
   output logic                              start_pend_o,
   output logic                              tx_cmd_o,
   output logic                              tx_pa_o,
   output logic                              tx_mod_o,
   output logic                              tx_data_o,
   output logic                              done_o,
   output logic                              irq_o,
   output logic                              underrun_o
);
   localparam int CW = $clog2(FIFO_DEPTH + 1);

   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("tx_ramp_sequencer: FIFO_DEPTH must be at least 2");
      end
      if (DLY_W < 1) begin : g_bad_dly
         $error("tx_ramp_sequencer: DLY_W must be at least 1");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("tx_ramp_sequencer: DIV_W must be at least 1");
      end
   endgenerate

   logic [7:0] fifo_q;
   logic       fifo_empty, fifo_full, pop, starved, stream_on;

   tx_ramp_fifo #(.DEPTH(FIFO_DEPTH), .DW(8), .CW(CW)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_i),
      .wr_data (wr_data_i),
      .rd_en   (pop),
      .rd_data (fifo_q),
      .empty   (fifo_empty),
      .full    (fifo_full),
      .count   (fifo_cnt_o)
   );

   assign drq_o = !fifo_full;

   tx_ramp_shifter #(.DIV_W(DIV_W), .LSB_FIRST(LSB_FIRST)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (stream_on),
      .baud_div   (baud_div_i),
      .fifo_empty (fifo_empty),
      .fifo_data  (fifo_q),
      .pop        (pop),
      .starved    (starved),
      .txd        (tx_data_o)
   );

   tx_ramp_ctrl #(.DLY_W(DLY_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .eof_i      (eof_i),
      .self_seq_i (self_seq_i),
      .cts_i      (cts_i),
      .up_cfg     (ramp_up_cfg_i),
      .dn_cfg     (ramp_dn_cfg_i),
      .starved    (starved),
      .stream_on  (stream_on),
      .start_pend (start_pend_o),
      .en_cmd     (tx_cmd_o),
      .en_pa      (tx_pa_o),
      .en_mod     (tx_mod_o),
      .done       (done_o),
      .irq        (irq_o),
      .underrun   (underrun_o)
   );

endmodule

// File: rtl/tx_ramp_checker.sv
module tx_ramp_checker #(
   parameter int FIFO_DEPTH = 8,
   parameter int CW         = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_pend_o,
   input logic          tx_cmd_o,
   input logic          tx_pa_o,
   input logic          tx_mod_o,
   input logic          tx_data_o,
   input logic          done_o,
   input logic          irq_o,
   input logic          underrun_o,
   input logic          drq_o,
   input logic [CW-1:0] fifo_cnt_o
);
   // R1
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(start_pend_o) |-> tx_cmd_o);
   // R2
   pa_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pa_o |-> tx_cmd_o);
   // R2
   mod_needs_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_mod_o |-> tx_pa_o);
   // R2
   pa_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_pa_o) |-> $past(tx_cmd_o));
   // R3
   data_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_data_o |-> tx_cmd_o);
   // R5
   cmd_off_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_cmd_o) |-> !tx_pa_o && !tx_mod_o);
   // R5
   pa_off_after_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_pa_o) |-> !tx_mod_o);
   // R6
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);
   // R6
   irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> done_o && !tx_cmd_o);
   // R7
   urun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(underrun_o) |-> $past(start_pend_o));
   // R10
   fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt_o <= CW'(FIFO_DEPTH));
   // R10
   drq_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drq_o == (fifo_cnt_o != CW'(FIFO_DEPTH)));
endmodule

bind tx_ramp_sequencer tx_ramp_checker #(
   .FIFO_DEPTH (FIFO_DEPTH),
   .CW         ($clog2(FIFO_DEPTH + 1))
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_pend_o (start_pend_o),
   .tx_cmd_o     (tx_cmd_o),
   .tx_pa_o      (tx_pa_o),
   .tx_mod_o     (tx_mod_o),
   .tx_data_o    (tx_data_o),
   .done_o       (done_o),
   .irq_o        (irq_o),
   .underrun_o   (underrun_o),
   .drq_o        (drq_o),
   .fifo_cnt_o   (fifo_cnt_o)
);

// File: tb/tb_tx_ramp_sequencer.sv
module tb_tx_ramp_sequencer;
   localparam int DEPTH = 8;
   localparam int DLY_W = 4;
   localparam int DIV_W = 4;
   localparam int CW    = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic               rst_n, wr_en, start, eof, self_seq, cts;
   logic [7:0]         wr_data;
   logic [3*DLY_W-1:0] up_cfg, dn_cfg;
   logic [DIV_W-1:0]   baud_div;
   logic               drq, start_pend, tx_cmd, tx_pa, tx_mod, tx_data, done, irq, urun;
   logic [CW-1:0]      fifo_cnt;

   tx_ramp_sequencer #(.FIFO_DEPTH(DEPTH), .DLY_W(DLY_W), .DIV_W(DIV_W)) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en_i       (wr_en),
      .wr_data_i     (wr_data),
      .drq_o         (drq),
      .fifo_cnt_o    (fifo_cnt),
      .start_i       (start),
      .eof_i         (eof),
      .self_seq_i    (self_seq),
      .cts_i         (cts),
      .ramp_up_cfg_i (up_cfg),
      .ramp_dn_cfg_i (dn_cfg),
      .baud_div_i    (baud_div),
      .start_pend_o  (start_pend),
      .tx_cmd_o      (tx_cmd),
      .tx_pa_o       (tx_pa),
      .tx_mod_o      (tx_mod),
      .tx_data_o     (tx_data),
      .done_o        (done),
      .irq_o         (irq),
      .underrun_o    (urun)
   );

   int cyc = 0;
   int n_chk = 0;
   int n_err = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      if (cyc > 150000) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog (all requirements): actual=%0d cycles expected=<150000", cyc);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic chk_eq(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int s, input int i);
      return 8'(s * 37 + i * 91 + 5);
   endfunction

   task automatic run_frame(input int nb, input int div,
                            input int u0, input int u1, input int u2,
                            input int d0, input int d1, input int d2,
                            input bit cts_mode, input bit with_eof, input int seed);
      int nexp = (nb > DEPTH) ? DEPTH : nb;
      int cmd_r = -1, pa_r = -1, mod_r = -1;
      int cmd_f = -1, pa_f = -1, mod_f = -1;
      int irq_t = -1, irq_n = 0, done_at_irq = 0;
      int t0 = -1, t_end, bitn = 0, bad_bits = 0, early = 0, wait_bad = 0, side = 0;
      logic ppa = 1'b0, pmod = 1'b0, pcmd = 1'b1;
      logic [7:0] b;

      @(negedge clk);
      baud_div = DIV_W'(div);
      up_cfg   = {DLY_W'(u2), DLY_W'(u1), DLY_W'(u0)};
      dn_cfg   = {DLY_W'(d2), DLY_W'(d1), DLY_W'(d0)};
      self_seq = cts_mode;
      cts      = 1'b0;
      for (int i = 0; i < nb; i++) begin
         wr_en   = 1'b1;
         wr_data = pat(seed, i);
         @(negedge clk);
      end
      wr_en = 1'b0;
      // R10: count, request flag and dropped overflow while idle
      chk_eq("R10", "fifo count after load", int'(fifo_cnt), nexp);
      chk_eq("R10", "drq after load", int'(drq), int'(nexp < DEPTH));
      if (with_eof) begin
         eof = 1'b1;
         @(negedge clk);
         eof = 1'b0;
      end
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk_eq("R1", "pending after start pulse", int'(start_pend), 1);
      chk_eq("R1", "cmd still low", int'(tx_cmd), 0);
      @(negedge clk);
      chk_eq("R1", "pending cleared", int'(start_pend), 0);
      chk_eq("R1", "cmd raised", int'(tx_cmd), 1);
      chk_eq("R11", "done cleared at start", int'(done), 0);
      chk_eq("R11", "underrun cleared at start", int'(urun), 0);
      cmd_r = cyc;

      for (int k = 0; k < 5000; k++) begin
         if (irq_t >= 0 && cyc > irq_t) break;
         if (tx_pa && !ppa && pa_r < 0) pa_r = cyc;
         if (tx_mod && !pmod && mod_r < 0) begin
            mod_r = cyc;
            if (!cts_mode) t0 = cyc + u2 + 2;
         end
         if (!tx_mod && pmod) mod_f = cyc;
         if (!tx_pa && ppa) pa_f = cyc;
         if (!tx_cmd && pcmd && cmd_f < 0) cmd_f = cyc;
         if (irq) begin
            irq_n++;
            if (irq_t < 0) begin
               irq_t = cyc;
               done_at_irq = int'(done);
            end
         end
         if (tx_pa || tx_mod) side++;
         if (cts_mode && cyc <= cmd_r + 3 && (tx_data || !tx_cmd)) wait_bad++;
         if (cts_mode && cyc == cmd_r + 3) begin
            cts = 1'b1;
            t0  = cyc + 2;
         end
         if (t0 < 0 || cyc < t0) begin
            if (tx_data) early++;
         end else if (bitn < 8 * nexp && ((cyc - t0) % (div + 1)) == div / 2) begin
            b = pat(seed, bitn / 8);
            if (tx_data != b[bitn % 8]) bad_bits++;
            bitn++;
         end
         ppa  = tx_pa;
         pmod = tx_mod;
         pcmd = tx_cmd;
         @(negedge clk);
      end
      cts = 1'b0;

      t_end = t0 + 8 * nexp * (div + 1);
      chk_eq("R3", "data before first bit slot", early, 0);
      chk_eq("R4", "bits sampled", bitn, 8 * nexp);
      chk_eq("R4", "bit mismatches LSB first", bad_bits, 0);
      if (!cts_mode) begin
         chk_eq("R2", "cmd to pa gap", pa_r - cmd_r, u0 + 1);
         chk_eq("R2", "pa to mod gap", mod_r - pa_r, u1 + 1);
         if (with_eof)
            chk_eq("R5", "mod fall after last bit", mod_f, t_end + d0 + 1);
         else
            chk_eq("R7", "mod fall on underrun edge", mod_f, t_end);
         chk_eq(with_eof ? "R5" : "R7", "mod to pa fall gap", pa_f - mod_f, d1 + 1);
         chk_eq(with_eof ? "R5" : "R7", "pa to cmd fall gap", cmd_f - pa_f, d2 + 1);
      end else begin
         chk_eq("R8", "pa or mod seen in handshake mode", side, 0);
         chk_eq("R9", "bad cycles while waiting for cts", wait_bad, 0);
         chk_eq("R8", "cmd fall at frame end", cmd_f, t_end);
      end
      chk_eq("R6", "irq on cmd fall", irq_t, cmd_f);
      chk_eq("R6", "irq pulse length", irq_n, 1);
      chk_eq("R6", "done at irq", done_at_irq, 1);
      chk_eq("R6", "done held", int'(done), 1);
      chk_eq("R7", "underrun flag", int'(urun), int'(!with_eof));
      chk_eq("R10", "fifo drained", int'(fifo_cnt), 0);
      chk_eq("R10", "drq with empty fifo", int'(drq), 1);
   endtask

   initial begin
      rst_n    = 1'b0;
      wr_en    = 1'b0;
      wr_data  = '0;
      start    = 1'b0;
      eof      = 1'b0;
      self_seq = 1'b0;
      cts      = 1'b0;
      up_cfg   = '0;
      dn_cfg   = '0;
      baud_div = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 R6 R7 R10: state right after reset
      chk_eq("R1", "reset cmd", int'(tx_cmd), 0);
      chk_eq("R1", "reset pending", int'(start_pend), 0);
      chk_eq("R2", "reset pa/mod", int'(tx_pa) + int'(tx_mod), 0);
      chk_eq("R6", "reset done/irq", int'(done) + int'(irq), 0);
      chk_eq("R7", "reset underrun", int'(urun), 0);
      chk_eq("R10", "reset drq", int'(drq), 1);
      chk_eq("R10", "reset count", int'(fifo_cnt), 0);

      run_frame(3, 1, 1, 2, 3, 2, 1, 0, 1'b0, 1'b1, 1);
      run_frame(8, 0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b1, 2);
      run_frame(1, 3, 15, 0, 7, 15, 3, 9, 1'b0, 1'b1, 3);
      // R11: previous eof is used up, so this frame underruns
      run_frame(2, 2, 2, 2, 2, 3, 3, 3, 1'b0, 1'b0, 4);
      run_frame(0, 1, 1, 1, 1, 1, 1, 1, 1'b0, 1'b0, 5);
      run_frame(0, 1, 2, 0, 1, 4, 0, 2, 1'b0, 1'b1, 6);
      // R10: ninth byte dropped
      run_frame(9, 0, 1, 1, 1, 1, 1, 1, 1'b0, 1'b1, 7);
      run_frame(3, 1, 5, 5, 5, 5, 5, 5, 1'b1, 1'b1, 8);
      run_frame(2, 0, 0, 0, 0, 0, 0, 0, 1'b1, 1'b0, 9);
      run_frame(0, 2, 0, 0, 0, 0, 0, 0, 1'b1, 1'b1, 10);
      for (int dv = 0; dv < 4; dv++) begin
         run_frame(1, dv, dv, 3 - dv, dv * 2, 3 - dv, dv, dv + 1, 1'b0, 1'b1, 20 + dv);
         run_frame(4, dv, 3, dv, 1, dv, 2, 0, 1'b0, 1'b1, 30 + dv);
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule